// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is a watchdog timer that sits on a simple 32-bit register bus. It has an 8-bit up-counter and a control/status register. Every write must carry a key byte in bits 31:24, and each register has its own key. A write with the wrong key is dropped. A 3-bit clock-select code picks a power-of-two prescaler ratio from 32 up to 4096. The counter advances once per prescaler period while it is enabled. When it wraps from 0xFF to 0x00 it sets an overflow flag and then, depending on a mode bit, either pulses a reset output for one cycle or holds an interrupt output high.

Software keeps the system alive by rewriting the counter with a keyed write before it wraps. It clears a raised flag with a keyed control write that has the flag bit at 0. The counter is read back at its own read address, which differs from its write address. The control/status register is read and written at the same address.

A small state machine tracks the timer activity:
- ST_HALT: the timer is disabled.
- ST_COUNT: the timer is running.
- ST_PULSE: a one-cycle state that drives the reset output.

The transitions are:
- enable_seen: ST_HALT to ST_COUNT when the enable bit is set.
- disable_seen: ST_COUNT to ST_HALT when the enable bit is cleared.
- trip_reset: ST_COUNT to ST_PULSE on an overflow while reset mode is selected.
- pulse_done: ST_PULSE goes back to ST_COUNT, or to ST_HALT if the timer was disabled in the meantime.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, the counter reads 0, the control/status register reads 0 (disabled, interrupt mode, flag clear, select code 0), and both outputs are low.
- R2: A write to address 0x0 whose bits 31:24 are 0x5A loads bits 7:0 into the counter, which then reads back at address 0x8. Such a write made while the timer runs restarts the count and prevents an overflow.
- R3: A write to address 0x4 whose bits 31:24 are 0xA5 sets the fields from its low byte: enable in bit 7, mode in bit 6, select code in bits 2:0. Reading address 0x4 returns these fields in the same positions and the flag in bit 3. Bits 5:4 read as 0.
- R4: A write whose key byte does not match the addressed register changes no state. This includes using the other register's key.
- R5: While enabled with select code s, the counter increments every 32·2^s clocks. The first increment comes 32·2^s clocks after the clock edge of the enabling write.
- R6: While the enable bit is 0, the counter holds its value.
- R7: When the counter wraps from 0xFF to 0x00, the flag (bit 3) is set.
- R8: With mode = 1, the reset output is high for exactly one cycle, the cycle right after the wrap edge, and the interrupt output stays low.
- R9: With mode = 0, the interrupt output is high for as long as the flag is set, and the reset output stays low.
- R10: A keyed control write with bit 3 = 0 clears the flag. A keyed control write with bit 3 = 1 leaves the flag unchanged and never sets it.
- R11: The prescaler restarts from zero when the select code changes or when the enable bit goes from 0 to 1.
- R12: Read data bits 31:8 are always 0, and a read of an address that has no readable register (0x0 or 0xC) returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data, key byte in bits 31:24 |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Read data (combinational) |
| wdt_rst_o | output | 1 | One-cycle reset pulse on overflow in mode 1 |
| wdt_irq_o | output | 1 | Interrupt, high while the flag is set in mode 0 |

## Verification
The hardest event to reach from the ports is the wrap, since a cleared counter at the slowest ratio needs over a million clocks to get there. The bench first preloads the counter to 0xFF with a keyed write and only then enables the timer. The wrap then lands exactly one prescaler period after the enabling edge, so the one-cycle reset pulse can be sampled in a known cycle. The prescaler restart is exposed by changing the select code partway through a period. A design that kept counting would tick well before the newly expected cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int DATA_W    = 32;
    localparam int KEY_LSB   = 24;
    localparam int SEL_W     = 3;
    localparam int BIT_EN    = 7;
    localparam int BIT_MODE  = 6;
    localparam int BIT_FLAG  = 3;
    localparam logic [7:0] KEY_COUNT = 8'h5A;
    localparam logic [7:0] KEY_CTRL  = 8'hA5;

    typedef struct packed {
        logic             en;
        logic             mode;
        logic             flag;
        logic [SEL_W-1:0] sel;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_COUNT = 2'd1,
        ST_PULSE = 2'd2
    } wd_state_e;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 8,
    parameter logic [ADDR_W-1:0] CNT_WR_ADDR = 4'h0,
    parameter logic [ADDR_W-1:0] CTL_ADDR    = 4'h4,
    parameter logic [ADDR_W-1:0] CNT_RD_ADDR = 4'h8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              ovf_evt,
    input  logic [CNT_W-1:0]  cnt_q,
    output ctrl_t             ctrl_q,
    output logic              cnt_load,
    output logic [CNT_W-1:0]  cnt_load_val,
    output logic              pre_restart,
    output logic [DATA_W-1:0] rd_data
);
    logic [7:0]       key_byte;
    logic             ctl_wr;
    logic             nxt_en;
    logic [SEL_W-1:0] nxt_sel;

    assign key_byte     = wr_data[DATA_W-1:KEY_LSB];
    assign cnt_load     = wr_en && (wr_addr == CNT_WR_ADDR) && (key_byte == KEY_COUNT);
    assign ctl_wr       = wr_en && (wr_addr == CTL_ADDR) && (key_byte == KEY_CTRL);
    assign cnt_load_val = wr_data[CNT_W-1:0];
    assign nxt_en       = wr_data[BIT_EN];
    assign nxt_sel      = wr_data[SEL_W-1:0];
    assign pre_restart  = ctl_wr && ((nxt_en && !ctrl_q.en) || (nxt_sel != ctrl_q.sel));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctl_wr) begin
            ctrl_q.en   <= nxt_en;
            ctrl_q.mode <= wr_data[BIT_MODE];
            ctrl_q.sel  <= nxt_sel;
            ctrl_q.flag <= (ctrl_q.flag & wr_data[BIT_FLAG]) | ovf_evt;
        end else begin
            ctrl_q.flag <= ctrl_q.flag | ovf_evt;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == CNT_RD_ADDR) begin
            rd_data[CNT_W-1:0] = cnt_q;
        end else if (rd_addr == CTL_ADDR) begin
            rd_data[BIT_EN]      = ctrl_q.en;
            rd_data[BIT_MODE]    = ctrl_q.mode;
            rd_data[BIT_FLAG]    = ctrl_q.flag;
            rd_data[SEL_W-1:0]   = ctrl_q.sel;
        end
    end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int SEL_W     = 3,
    parameter int BASE_LOG2 = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int NUM_DIV = 1 << SEL_W;
    localparam int PRE_W   = BASE_LOG2 + NUM_DIV - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] term [NUM_DIV];

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_term
        assign term[g] = PRE_W'((64'd1 << (BASE_LOG2 + g)) - 64'd1);
    end

    assign tick = run && (pre_q == term[sel]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run || restart || tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf_evt
);
    assign ovf_evt = tick && !load && (&cnt_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic mode,
    input  logic flag,
    input  logic ovf_evt,
    output logic rst_pulse,
    output logic irq
);
    wd_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:  if (en) state_d = ST_COUNT;
            ST_COUNT: begin
                if (ovf_evt && mode) state_d = ST_PULSE;
                else if (!en)        state_d = ST_HALT;
            end
            ST_PULSE: state_d = en ? ST_COUNT : ST_HALT;
            default:  state_d = ST_HALT;
        endcase
    end

    always_comb begin
        rst_pulse = (state_q == ST_PULSE);
        irq       = flag && !mode;
    end
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
    import wdt_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CNT_W     = 8,
    parameter int BASE_LOG2 = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic              wdt_rst_o,
    output logic              wdt_irq_o
);
    ctrl_t            ctrl_q;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_load_val;
    logic [CNT_W-1:0] cnt_q;
    logic             pre_restart;
    logic             tick;
    logic             ovf_evt;

    wdt_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .ovf_evt(ovf_evt),
        .cnt_q(cnt_q), .ctrl_q(ctrl_q), .cnt_load(cnt_load),
        .cnt_load_val(cnt_load_val), .pre_restart(pre_restart),
        .rd_data(rd_data)
    );

    wdt_prescaler #(.SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2)) pre_i (
        .clk(clk), .rst_n(rst_n), .run(ctrl_q.en), .restart(pre_restart),
        .sel(ctrl_q.sel), .tick(tick)
    );

    wdt_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(cnt_load),
        .load_val(cnt_load_val), .cnt_q(cnt_q), .ovf_evt(ovf_evt)
    );

    wdt_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .en(ctrl_q.en), .mode(ctrl_q.mode),
        .flag(ctrl_q.flag), .ovf_evt(ovf_evt),
        .rst_pulse(wdt_rst_o), .irq(wdt_irq_o)
    );
endmodule

// File: rtl/wdt_keyed_sva.sv
module wdt_keyed_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] key_byte,
    input logic       tick,
    input logic       cnt_load,
    input logic [7:0] cnt_q,
    input logic       ovf_evt,
    input logic       en,
    input logic       mode,
    input logic       flag,
    input logic [2:0] sel,
    input logic       rst_o,
    input logic       irq_o
);
    // R8
    rst_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_o |=> !rst_o);
    // R8
    rst_pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_o) |-> $past(ovf_evt));
    // R7
    flag_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> flag);
    // R5
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_load) |=> $stable(cnt_q));
    // R4
    bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && key_byte != 8'h5A && key_byte != 8'hA5) |=> $stable({en, mode, sel}));
    // R9
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(wr_en));
endmodule

bind wdt_keyed wdt_keyed_sva sva_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .key_byte(wr_data[31:24]),
    .tick(tick), .cnt_load(cnt_load), .cnt_q(cnt_q), .ovf_evt(ovf_evt),
    .en(ctrl_q.en), .mode(ctrl_q.mode), .flag(ctrl_q.flag), .sel(ctrl_q.sel),
    .rst_o(wdt_rst_o), .irq_o(wdt_irq_o)
);

// File: tb/wdt_keyed_tb_top.sv
module wdt_keyed_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] A_CNT_WR = 4'h0;
    localparam logic [3:0] A_CTL    = 4'h4;
    localparam logic [3:0] A_CNT_RD = 4'h8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        wdt_rst_o;
    logic        wdt_irq_o;
    int          checks = 0;
    int          errors = 0;
    logic [31:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_keyed dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .wdt_rst_o(wdt_rst_o), .wdt_irq_o(wdt_irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        wr_addr = a;
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset();
        bus_rd(A_CNT_RD, rv); check("R1 counter", rv, 32'h0);
        bus_rd(A_CTL, rv);    check("R1 control", rv, 32'h0);
        check("R1 rst_o", {31'b0, wdt_rst_o}, 32'h0);
        check("R1 irq_o", {31'b0, wdt_irq_o}, 32'h0);
    endtask

    task automatic t_regs_and_keys();
        do_reset();
        bus_wr(A_CNT_WR, 32'h5A00_0037);
        bus_rd(A_CNT_RD, rv); check("R2 load", rv, 32'h37);
        bus_wr(A_CNT_WR, 32'h5AFF_FF12);
        bus_rd(A_CNT_RD, rv); check("R2 low byte only", rv, 32'h12);
        bus_wr(A_CTL, 32'hA5FF_FF7F);
        bus_rd(A_CTL, rv); check("R3 fields", rv, 32'h47);
        bus_rd(4'hC, rv);  check("R12 unmapped", rv, 32'h0);
        bus_rd(A_CNT_WR, rv); check("R12 write-only addr", rv, 32'h0);
        bus_wr(A_CNT_WR, 32'hA500_0099);
        bus_rd(A_CNT_RD, rv); check("R4 count key swap", rv, 32'h12);
        bus_wr(A_CNT_WR, 32'h0000_0099);
        bus_rd(A_CNT_RD, rv); check("R4 count zero key", rv, 32'h12);
        bus_wr(A_CTL, 32'h5A00_0080);
        bus_rd(A_CTL, rv); check("R4 control key swap", rv, 32'h47);
    endtask

    task automatic t_rate();
        do_reset();
        bus_wr(A_CTL, 32'hA500_0080);
        wait_clk(31); bus_rd(A_CNT_RD, rv); check("R5 before first tick", rv, 32'h0);
        wait_clk(1);  bus_rd(A_CNT_RD, rv); check("R5 first tick div32", rv, 32'h1);
        wait_clk(32); bus_rd(A_CNT_RD, rv); check("R5 second tick div32", rv, 32'h2);
        bus_wr(A_CTL, 32'hA500_0000);
        wait_clk(200); bus_rd(A_CNT_RD, rv); check("R6 hold disabled", rv, 32'h2);
        do_reset();
        bus_wr(A_CTL, 32'hA500_0083);
        wait_clk(255); bus_rd(A_CNT_RD, rv); check("R5 before tick div256", rv, 32'h0);
        wait_clk(1);   bus_rd(A_CNT_RD, rv); check("R5 tick div256", rv, 32'h1);
    endtask

    task automatic t_restart();
        do_reset();
        bus_wr(A_CTL, 32'hA500_0082);
        wait_clk(100);
        bus_wr(A_CTL, 32'hA500_0083);
        wait_clk(255); bus_rd(A_CNT_RD, rv); check("R11 sel change restart", rv, 32'h0);
        wait_clk(1);   bus_rd(A_CNT_RD, rv); check("R11 tick after sel change", rv, 32'h1);
        bus_wr(A_CTL, 32'hA500_0080);
        wait_clk(20);
        bus_wr(A_CTL, 32'hA500_0000);
        wait_clk(3);
        bus_wr(A_CTL, 32'hA500_0080);
        wait_clk(31); bus_rd(A_CNT_RD, rv); check("R11 enable rise restart", rv, 32'h1);
        wait_clk(1);  bus_rd(A_CNT_RD, rv); check("R11 tick after enable", rv, 32'h2);
    endtask

    task automatic t_reset_mode();
        int highs;
        do_reset();
        bus_wr(A_CNT_WR, 32'h5A00_00FF);
        bus_wr(A_CTL, 32'hA500_00C0);
        wait_clk(31);
        check("R8 no early pulse", {31'b0, wdt_rst_o}, 32'h0);
        wait_clk(1);
        check("R8 pulse high", {31'b0, wdt_rst_o}, 32'h1);
        check("R8 irq low", {31'b0, wdt_irq_o}, 32'h0);
        bus_rd(A_CNT_RD, rv); check("R7 wrapped", rv, 32'h0);
        bus_rd(A_CTL, rv);    check("R7 flag set", rv, 32'hC8);
        wait_clk(1);
        check("R8 pulse one cycle", {31'b0, wdt_rst_o}, 32'h0);
        highs = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (wdt_rst_o) highs++;
        end
        check("R8 no repeat pulse", highs, 0);
        do_reset();
        bus_wr(A_CNT_WR, 32'h5A00_00FE);
        bus_wr(A_CTL, 32'hA500_00C0);
        highs = 0;
        for (int k = 0; k < 10; k++) begin
            wait_clk(20);
            bus_wr(A_CNT_WR, 32'h5A00_00FE);
            if (wdt_rst_o) highs++;
        end
        bus_rd(A_CTL, rv);
        check("R2 serviced no pulse", highs, 0);
        check("R2 serviced no flag", rv, 32'hC0);
    endtask

    task automatic t_irq_mode();
        do_reset();
        bus_wr(A_CNT_WR, 32'h5A00_00FF);
        bus_wr(A_CTL, 32'hA500_0080);
        wait_clk(32);
        check("R9 irq on wrap", {31'b0, wdt_irq_o}, 32'h1);
        check("R9 no rst", {31'b0, wdt_rst_o}, 32'h0);
        bus_rd(A_CTL, rv); check("R7 flag mode0", rv, 32'h88);
        wait_clk(10);
        check("R9 irq held", {31'b0, wdt_irq_o}, 32'h1);
        bus_wr(A_CTL, 32'hA500_0088);
        check("R10 write one keeps", {31'b0, wdt_irq_o}, 32'h1);
        bus_wr(A_CTL, 32'hA500_0080);
        check("R10 clear irq", {31'b0, wdt_irq_o}, 32'h0);
        bus_rd(A_CTL, rv); check("R10 flag cleared", rv, 32'h80);
        bus_wr(A_CTL, 32'hA500_0088);
        bus_rd(A_CTL, rv); check("R10 write one no set", rv, 32'h80);
    endtask

    task automatic finish_up();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        t_reset_state();
        t_regs_and_keys();
        t_rate();
        t_restart();
        t_reset_mode();
        t_irq_mode();
        finish_up();
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_up();
    end
endmodule